// File: doc/BRIEF.md
# Sliding-Window Bit Autocorrelation Accumulator

This block maintains a running correlation matrix of hard-decision user bits for a multiuser receiver. Each bit period the surrounding logic presents a vector of 2K decisions: the bits of K asynchronous users at the current and at the previous bit alignment. Alongside it comes the vector that is about to fall out of an L-period window. A start pulse launches one update sweep. During the sweep every matrix entry gains the product of two bits of the new vector. Once the window is full, every entry also loses the product of the same two bits of the departing vector.

A bit value of 1 stands for +1 and 0 for -1, so each product is a single XNOR gate. Each entry is a small signed up/down counter that saturates instead of wrapping. The sweep is serial: one entry is touched per clock, row by row. A full update therefore costs (2K)^2 cycles and ends with a done pulse. A read port returns any entry while the block is idle. A load input sets every entry to a chosen value and restarts the window fill count.

Top module: `bit_acorr_window`

## Requirements
- R1: After reset every entry reads 0, busy and done are low, and rdValid is high.
- R2: A sweep adds +1 to entry (row i, col j) when newBits[i] equals newBits[j] and adds -1 otherwise. Bit value 1 encodes +1 and 0 encodes -1. Row i is selected by rdRow and column j by rdCol.
- R3: While fewer than WIN_LEN sweeps have completed since reset or load, oldBits has no effect. After that, each sweep also adds -1 to entry (i,j) when oldBits[i] equals oldBits[j], and +1 otherwise.
- R4: A start seen on an idle clock edge sets busy on the next cycle. done is high for exactly one cycle, (2*NUM_USERS)^2 edges after the accepting edge, and busy falls at the same edge.
- R5: While busy, rdValid is 0 and rdData is 0. While idle, rdValid is 1 and rdData is the selected entry, combinationally.
- R6: Entries saturate at 127 and -128 (signed 8-bit, CNT_W=8) and never wrap. The net change of a sweep is applied first and the result is then clamped.
- R7: loadEn on an idle edge sets every entry to loadValue and clears the window fill count. A start on the same edge is dropped.
- R8: start and loadEn while busy are ignored. The bit vectors captured at the accepting edge are used for the whole sweep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an update sweep |
| loadEn | input | 1 | Load every entry with loadValue |
| loadValue | input | CNT_W | Signed initial value |
| newBits | input | 2*NUM_USERS | Decisions entering the window |
| oldBits | input | 2*NUM_USERS | Decisions leaving the window |
| rdRow | input | clog2(2*NUM_USERS) | Read row index |
| rdCol | input | clog2(2*NUM_USERS) | Read column index |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| rdValid | output | 1 | Read data valid |
| rdData | output | CNT_W | Signed entry value |

## Verification
The assertions assume that start and loadEn are sampled only at clock edges, and that reset has been held for at least one edge. They also assume that the read indices address a real row and column. The bench drives every input on the falling edge and keeps rdRow and rdCol inside 0 to 2K-1. It pulses start and loadEn in the middle of a sweep only to probe R8. The random vectors come from a fixed seed. The directed cases load values near both limits so that the saturation edges are reached within a few sweeps.

// File: rtl/acorr_pkg.sv
package acorr_pkg;
  // strobes from the sequencer to the counter array
  typedef struct packed {
    logic capture;   // latch the bit vectors
    logic load;      // initialise all entries
    logic step;      // one entry is updated this cycle
    logic subtract;  // departing term active for this sweep
  } accStrobe_t;
endpackage

// File: rtl/acorr_ctrl.sv
module acorr_ctrl
  import acorr_pkg::*;
#(
  parameter int NUM_USERS = 4,
  parameter int WIN_LEN   = 16,
  localparam int VEC_W = 2 * NUM_USERS,
  localparam int ELEMS = VEC_W * VEC_W,
  localparam int IDX_W = $clog2(ELEMS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             loadEn,
  output accStrobe_t       strb,
  output logic [IDX_W-1:0] stepIdx,
  output logic             busy,
  output logic             done
);
  localparam int FILL_W = $clog2(WIN_LEN + 1);

  logic [FILL_W-1:0] fillCnt;
  logic subEn;
  logic accept;
  logic doLoad;
  logic lastStep;

  assign accept   = start && !busy && !loadEn;
  assign doLoad   = loadEn && !busy;
  assign lastStep = busy && (stepIdx == IDX_W'(ELEMS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      stepIdx <= '0;
      fillCnt <= '0;
      subEn   <= 1'b0;
    end else begin
      done <= lastStep;
      if (doLoad) fillCnt <= '0;
      if (accept) begin
        busy    <= 1'b1;
        stepIdx <= '0;
        subEn   <= (fillCnt == FILL_W'(WIN_LEN));
      end else if (busy) begin
        if (lastStep) begin
          busy <= 1'b0;
          if (fillCnt != FILL_W'(WIN_LEN)) fillCnt <= fillCnt + FILL_W'(1);
        end else begin
          stepIdx <= stepIdx + IDX_W'(1);
        end
      end
    end
  end

  always_comb begin
    strb.capture  = accept;
    strb.load     = doLoad;
    strb.step     = busy;
    strb.subtract = subEn;
  end
endmodule

// File: rtl/acorr_datapath.sv
module acorr_datapath
  import acorr_pkg::*;
#(
  parameter int NUM_USERS = 4,
  parameter int CNT_W     = 8,
  localparam int VEC_W = 2 * NUM_USERS,
  localparam int ELEMS = VEC_W * VEC_W,
  localparam int IDX_W = $clog2(ELEMS),
  localparam int COL_W = $clog2(VEC_W)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  accStrobe_t              strb,
  input  logic [IDX_W-1:0]        stepIdx,
  input  logic                    busy,
  input  logic [VEC_W-1:0]        newBits,
  input  logic [VEC_W-1:0]        oldBits,
  input  logic signed [CNT_W-1:0] loadValue,
  input  logic [COL_W-1:0]        rdRow,
  input  logic [COL_W-1:0]        rdCol,
  output logic signed [CNT_W-1:0] rdData,
  output logic                    rdValid
);
  localparam logic signed [CNT_W:0] HI = $signed({2'b00, {(CNT_W-1){1'b1}}});
  localparam logic signed [CNT_W:0] LO = $signed({2'b11, {(CNT_W-1){1'b0}}});

  logic [VEC_W-1:0] newReg;
  logic [VEC_W-1:0] oldReg;
  logic signed [CNT_W-1:0] cells [ELEMS];

  function automatic logic signed [CNT_W-1:0] satAdd(
    input logic signed [CNT_W-1:0] v,
    input logic signed [2:0]       d
  );
    logic signed [CNT_W:0] s;
    s = $signed({v[CNT_W-1], v}) + $signed({{(CNT_W-2){d[2]}}, d});
    if (s > HI)      return HI[CNT_W-1:0];
    else if (s < LO) return LO[CNT_W-1:0];
    else             return s[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newReg <= '0;
      oldReg <= '0;
    end else if (strb.capture) begin
      newReg <= newBits;
      oldReg <= oldBits;
    end
  end

  // one counter per matrix entry, walked row-major by stepIdx
  for (genvar r = 0; r < VEC_W; r++) begin : g_row
    for (genvar c = 0; c < VEC_W; c++) begin : g_col
      localparam int E = r * VEC_W + c;
      logic pNew;
      logic pOld;
      logic hit;
      logic signed [2:0] inc;
      logic signed [2:0] dec;
      logic signed [2:0] delta;

      assign pNew = ~(newReg[r] ^ newReg[c]);
      assign pOld = ~(oldReg[r] ^ oldReg[c]);
      assign hit  = strb.step && (stepIdx == IDX_W'(E));

      always_comb begin
        inc   = pNew ? 3'sd1 : -3'sd1;
        dec   = !strb.subtract ? 3'sd0 : (pOld ? -3'sd1 : 3'sd1);
        delta = inc + dec;
      end

      always_ff @(posedge clk) begin
        if (!rstN)          cells[E] <= '0;
        else if (strb.load) cells[E] <= loadValue;
        else if (hit)       cells[E] <= satAdd(cells[E], delta);
      end
    end
  end

  logic [IDX_W-1:0] rdIdx;
  logic rdInRange;

  always_comb begin
    rdInRange = (int'(rdRow) < VEC_W) && (int'(rdCol) < VEC_W);
    rdIdx     = IDX_W'(int'(rdRow) * VEC_W + int'(rdCol));
    rdValid   = !busy;
    if (busy || !rdInRange) rdData = '0;
    else                    rdData = cells[rdIdx];
  end
endmodule

// File: rtl/bit_acorr_window.sv
module bit_acorr_window
  import acorr_pkg::*;
#(
  parameter int NUM_USERS = 4,
  parameter int WIN_LEN   = 16,
  parameter int CNT_W     = 8,
  localparam int VEC_W = 2 * NUM_USERS,
  localparam int COL_W = $clog2(VEC_W),
  localparam int IDX_W = $clog2(VEC_W * VEC_W)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    loadEn,
  input  logic signed [CNT_W-1:0] loadValue,
  input  logic [VEC_W-1:0]        newBits,
  input  logic [VEC_W-1:0]        oldBits,
  input  logic [COL_W-1:0]        rdRow,
  input  logic [COL_W-1:0]        rdCol,
  output logic                    busy,
  output logic                    done,
  output logic                    rdValid,
  output logic signed [CNT_W-1:0] rdData
);
  accStrobe_t strb;
  logic [IDX_W-1:0] stepIdx;

  acorr_ctrl #(.NUM_USERS(NUM_USERS), .WIN_LEN(WIN_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .loadEn(loadEn),
    .strb(strb), .stepIdx(stepIdx), .busy(busy), .done(done)
  );

  acorr_datapath #(.NUM_USERS(NUM_USERS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .stepIdx(stepIdx), .busy(busy),
    .newBits(newBits), .oldBits(oldBits), .loadValue(loadValue),
    .rdRow(rdRow), .rdCol(rdCol), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/acorr_checker.sv
module acorr_checker #(
  parameter int CNT_W = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    start,
  input logic                    loadEn,
  input logic                    busy,
  input logic                    done,
  input logic                    rdValid,
  input logic signed [CNT_W-1:0] rdData
);
  a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  a_r4_single_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r4_start_accept: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !loadEn) |=> busy);

  a_r5_read_blocked: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!rdValid && rdData == '0));

  a_r7_load_no_sweep: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && !busy) |=> (!busy && !done));
endmodule

bind bit_acorr_window acorr_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_bit_acorr_window.sv
module sim_bit_acorr_window;
  localparam int PERIOD = 10;
  localparam int K      = 4;
  localparam int L      = 16;
  localparam int W      = 8;
  localparam int N      = 2 * K;
  localparam int M      = N * N;
  localparam int CW     = $clog2(N);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic loadEn = 1'b0;
  logic signed [W-1:0] loadValue = '0;
  logic [N-1:0] newBits = '0;
  logic [N-1:0] oldBits = '0;
  logic [CW-1:0] rdRow = '0;
  logic [CW-1:0] rdCol = '0;
  logic busy, done, rdValid;
  logic signed [W-1:0] rdData;

  int checks = 0;
  int errors = 0;
  int expM [N][N];
  int fill = 0;

  always #(PERIOD/2) clk = ~clk;

  bit_acorr_window #(.NUM_USERS(K), .WIN_LEN(L), .CNT_W(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .loadEn(loadEn), .loadValue(loadValue),
    .newBits(newBits), .oldBits(oldBits), .rdRow(rdRow), .rdCol(rdCol),
    .busy(busy), .done(done), .rdValid(rdValid), .rdData(rdData)
  );

  function automatic int clampV(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int prod(logic [N-1:0] v, int i, int j);
    return (v[i] == v[j]) ? 1 : -1;
  endfunction

  task automatic modelSweep(logic [N-1:0] nb, logic [N-1:0] ob);
    bit full = (fill == L);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        expM[i][j] = clampV(expM[i][j] + prod(nb, i, j) - (full ? prod(ob, i, j) : 0));
    if (fill < L) fill++;
  endtask

  task automatic check(bit ok, string tag, int got, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic compareMatrix(string tag);
    int bad = 0;
    int g = 0;
    int e = 0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        @(negedge clk);
        rdRow = CW'(i);
        rdCol = CW'(j);
        #1;
        if (bad == 0 && (int'(rdData) != expM[i][j] || !rdValid)) begin
          bad = 1; g = int'(rdData); e = expM[i][j];
        end
      end
    check(bad == 0, tag, g, e);
  endtask

  // disturb: 0 none, 1 start mid-sweep, 2 load mid-sweep
  task automatic sweep(logic [N-1:0] nb, logic [N-1:0] ob, int disturb);
    bit early = 0;
    @(negedge clk);
    newBits = nb; oldBits = ob; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !rdValid && rdData == 0, "R5 blocked read", int'(rdValid), 0);
    for (int k = 1; k < M; k++) begin
      if (done) early = 1;
      @(negedge clk);
      if (k == 2) begin newBits = ~nb; oldBits = ~ob; end
      if (k == 3) begin start = (disturb == 1); loadEn = (disturb == 2); loadValue = 8'sd99; end
      if (k == 4) begin start = 1'b0; loadEn = 1'b0; end
    end
    if (done) early = 1;
    check(!early, "R4 no early done", int'(early), 0);
    @(negedge clk);
    check(done && !busy, "R4 done timing", int'(done), 1);
    modelSweep(nb, ob);
    if (disturb != 0) begin
      bit extra = 0;
      for (int k = 0; k < M + 4; k++) begin
        @(negedge clk);
        if (done || busy) extra = 1;
      end
      check(!extra, "R8 ignored while busy", int'(extra), 0);
    end
  endtask

  task automatic doLoad(int v, bit withStart);
    @(negedge clk);
    loadEn = 1'b1; loadValue = W'(v); start = withStart;
    @(negedge clk);
    loadEn = 1'b0; start = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) expM[i][j] = v;
    fill = 0;
    if (withStart) check(!busy, "R7 load beats start", int'(busy), 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired got 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) expM[i][j] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(!busy && !done && rdValid, "R1 idle after reset", int'(busy), 0);
    compareMatrix("R1 zero matrix");

    // window filling then full: R2 before L sweeps, R3 after
    for (int s = 0; s < L + 6; s++) begin
      sweep(N'($urandom), N'($urandom), 0);
      compareMatrix(s < L ? "R2 add new product" : "R3 departing subtract");
    end
    begin
      logic [N-1:0] v = N'($urandom);
      sweep(v, v, 0);
      compareMatrix("R3 equal in/out no change");
    end

    sweep(N'($urandom), N'($urandom), 1);
    compareMatrix("R8 start mid-sweep");
    sweep(N'($urandom), N'($urandom), 2);
    compareMatrix("R8 load mid-sweep");

    doLoad(-20, 1'b0);
    compareMatrix("R7 load value");
    sweep(N'($urandom), N'($urandom), 0);
    compareMatrix("R3 fill restarted by load");

    doLoad(125, 1'b0);
    for (int s = 0; s < 4; s++) sweep('1, '0, 0);
    compareMatrix("R6 upper clamp");
    @(negedge clk); rdRow = 0; rdCol = 1; #1;
    check(int'(rdData) == 127, "R6 entry held at 127", int'(rdData), 127);

    doLoad(-126, 1'b0);
    for (int s = 0; s < 4; s++) sweep(8'b0101_0101, '0, 0);
    compareMatrix("R6 lower clamp");
    @(negedge clk); rdRow = 0; rdCol = 1; #1;
    check(int'(rdData) == -128, "R6 entry held at -128", int'(rdData), -128);

    doLoad(5, 1'b1);
    compareMatrix("R7 start dropped with load");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule